// File: doc/BRIEF.md
# Stride-Aware Gray Address Bus Encoder

This block drives a heavily loaded address bus with an instruction address stream in a code that costs little switching. Most fetch addresses follow one another by one word. The block therefore leaves the byte-offset bits below the word size as they are and converts only the word index above them to reflected Gray code. A step of one word (4 bytes in narrow mode, 8 bytes in wide mode) then changes exactly one bus line. A jump to any other address is encoded just as correctly, but it may change several lines.

The encoded value sits in a bus register. That register loads only on a cycle with the valid strobe and holds in idle cycles, so idle cycles cause no toggles. A decoder for the receive side turns the registered bus value back into the binary address. It uses the stride mode that was registered with that bus value. A toggle count output reports how many bus lines the most recent register update changed. This makes the switching cost of an address stream visible at the ports.

Top module: `sgb_bus_enc`

## Requirements
- R1: While rst_ni is low, and until the first accepted address, bus_o, dec_addr_o and toggles_o are all zero.
- R2: In narrow mode (wide_i = 0), one cycle after a cycle with valid_i high, bus_o[1:0] equals addr_i[1:0] and bus_o[AW-1:2] equals u ^ (u >> 1), where u = addr_i >> 2. This holds for any address, including jumps.
- R3: In wide mode (wide_i = 1), one cycle after a cycle with valid_i high, bus_o[2:0] equals addr_i[2:0] and bus_o[AW-1:3] equals u ^ (u >> 1), where u = addr_i >> 3.
- R4: An accepted address that equals the previous accepted address plus the stride (4 in narrow mode, 8 in wide mode), in the same mode, changes exactly one bus line, and toggles_o reads 1.
- R5: A cycle with valid_i low leaves bus_o unchanged and sets toggles_o to 0 in the next cycle. This holds whatever addr_i and wide_i carry in that cycle.
- R6: One cycle after an accepted address, toggles_o equals the number of bus_o bits that differ from their value before the update.
- R7: dec_addr_o equals the most recently accepted address, in both modes, from the cycle after acceptance.
- R8: A sequential step that wraps the address from the top word to zero (0xFFFFFFFC to 0 in narrow mode, 0xFFFFFFF8 to 0 in wide mode) also changes exactly one bus line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | Binary byte address |
| valid_i | input | 1 | Address strobe; the bus register loads only when it is high |
| wide_i | input | 1 | Stride mode: 0 = 4-byte words, 1 = 8-byte words |
| bus_o | output | AW | Encoded bus value (registered) |
| dec_addr_o | output | AW | Address recovered from bus_o by the receive-side decoder |
| toggles_o | output | $clog2(AW+1) | Bus lines changed by the latest update; 0 after an idle cycle |

## Verification
The bus register and the stored mode are the only state, and both appear at the ports one cycle after every accepted address. A wrong low-bit width, a wrong Gray conversion or a stale mode therefore shows up at once, in the next cycle, as a bus_o value the bench's encoder function does not predict. The same error also shows as a dec_addr_o that differs from the address just sent. An error in the hold logic or in the toggle count shows up on the first idle cycle or the first sequential step as a moving bus or a toggle count other than 0 or 1.

// File: rtl/sgb_pkg.sv
package sgb_pkg;
  typedef enum logic {
    STRIDE_W4 = 1'b0,
    STRIDE_W8 = 1'b1
  } stride_e;

  // number of byte-offset bits left unencoded for a stride mode
  function automatic int unsigned low_bits(stride_e m);
    return (m == STRIDE_W8) ? 3 : 2;
  endfunction
endpackage

// File: rtl/sgb_encoder.sv
module sgb_encoder
  import sgb_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] addr_i,
  input  stride_e       mode_i,
  output logic [AW-1:0] code_o
);
  localparam logic [AW-1:0] ONES = '1;

  logic [AW-1:0] low_mask;
  logic [AW-1:0] word_idx;
  logic [AW-1:0] gray_idx;

  always_comb begin
    low_mask = ~(ONES << low_bits(mode_i));
    word_idx = addr_i >> low_bits(mode_i);
    gray_idx = word_idx ^ (word_idx >> 1);
    code_o   = (gray_idx << low_bits(mode_i)) | (addr_i & low_mask);
  end
endmodule

// File: rtl/sgb_decoder.sv
module sgb_decoder
  import sgb_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] code_i,
  input  stride_e       mode_i,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] ONES = '1;

  // prefix XOR from the MSB down undoes g = b ^ (b >> 1)
  function automatic logic [AW-1:0] gray_to_bin(logic [AW-1:0] g);
    logic [AW-1:0] b;
    b[AW-1] = g[AW-1];
    for (int i = AW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [AW-1:0] low_mask;
  logic [AW-1:0] bin_idx;

  always_comb begin
    low_mask = ~(ONES << low_bits(mode_i));
    bin_idx  = gray_to_bin(code_i >> low_bits(mode_i));
    addr_o   = (bin_idx << low_bits(mode_i)) | (code_i & low_mask);
  end
endmodule

// File: rtl/sgb_popcount.sv
module sgb_popcount #(
  parameter int unsigned W = 32,
  localparam int unsigned CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) cnt_o = cnt_o + CW'(vec_i[i]);
  end
endmodule

// File: rtl/sgb_bus_enc.sv
module sgb_bus_enc
  import sgb_pkg::*;
#(
  parameter int unsigned AW = 32,
  localparam int unsigned CW = $clog2(AW + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          valid_i,
  input  logic          wide_i,
  output logic [AW-1:0] bus_o,
  output logic [AW-1:0] dec_addr_o,
  output logic [CW-1:0] toggles_o
);
  stride_e       mode_in;
  stride_e       mode_q;
  logic [AW-1:0] code_d;
  logic [AW-1:0] bus_q;
  logic [CW-1:0] flips_d;
  logic [CW-1:0] toggles_q;

  assign mode_in = stride_e'(wide_i);

  sgb_encoder #(.AW(AW)) u_enc (
    .addr_i (addr_i),
    .mode_i (mode_in),
    .code_o (code_d)
  );

  sgb_popcount #(.W(AW)) u_pop (
    .vec_i (bus_q ^ code_d),
    .cnt_o (flips_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_q     <= '0;
      mode_q    <= STRIDE_W4;
      toggles_q <= '0;
    end else if (valid_i) begin
      bus_q     <= code_d;
      mode_q    <= mode_in;
      toggles_q <= flips_d;
    end else begin
      toggles_q <= '0;
    end
  end

  sgb_decoder #(.AW(AW)) u_dec (
    .code_i (bus_q),
    .mode_i (mode_q),
    .addr_o (dec_addr_o)
  );

  assign bus_o     = bus_q;
  assign toggles_o = toggles_q;
endmodule

// File: rtl/sgb_bus_enc_chk.sv
module sgb_bus_enc_chk #(
  parameter int unsigned AW = 32,
  localparam int unsigned CW = $clog2(AW + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] addr_i,
  input logic          valid_i,
  input logic          wide_i,
  input logic [AW-1:0] bus_o,
  input logic [AW-1:0] dec_addr_o,
  input logic [CW-1:0] toggles_o
);
  logic [AW-1:0] last_addr_q;
  logic          last_wide_q;
  logic          have_q;
  logic [AW-1:0] stride;
  logic          seq_step;

  assign stride   = wide_i ? AW'(8) : AW'(4);
  assign seq_step = valid_i && have_q && (wide_i == last_wide_q) &&
                    (addr_i == last_addr_q + stride);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_addr_q <= '0;
      last_wide_q <= 1'b0;
      have_q      <= 1'b0;
    end else if (valid_i) begin
      last_addr_q <= addr_i;
      last_wide_q <= wide_i;
      have_q      <= 1'b1;
    end
  end

  always_comb begin
    if (!rst_ni) assert_reset_zero_R1: assert (bus_o == '0 && toggles_o == '0);
  end

  assert_low_narrow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !wide_i) |=> bus_o[1:0] == $past(addr_i[1:0]));

  assert_low_wide_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && wide_i) |=> bus_o[2:0] == $past(addr_i[2:0]));

  assert_one_flip_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_step |=> (toggles_o == CW'(1) && $countones(bus_o ^ $past(bus_o)) == 1));

  assert_idle_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(bus_o) && toggles_o == '0));

  assert_flip_count_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> toggles_o == CW'($countones(bus_o ^ $past(bus_o))));

  assert_round_trip_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> dec_addr_o == $past(addr_i));
endmodule

bind sgb_bus_enc sgb_bus_enc_chk #(.AW(AW)) u_chk (.*);

// File: tb/sgb_bus_enc_test.sv
`timescale 1ns/1ps
module sgb_bus_enc_test;
  localparam int unsigned AW = 32;
  localparam int unsigned CW = $clog2(AW + 1);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          valid_i = 1'b0;
  logic          wide_i = 1'b0;
  logic [AW-1:0] bus_o;
  logic [AW-1:0] dec_addr_o;
  logic [CW-1:0] toggles_o;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  logic [AW-1:0] exp_bus = '0;
  logic [AW-1:0] exp_dec = '0;
  logic [AW-1:0] cur_addr = '0;
  logic          cur_wide = 1'b0;

  always #2.5 clk_i = ~clk_i;

  sgb_bus_enc #(.AW(AW)) uut (.*);

  function automatic logic [AW-1:0] ref_enc(logic [AW-1:0] a, logic w);
    int unsigned l = w ? 3 : 2;
    logic [AW-1:0] u = a >> l;
    logic [AW-1:0] m = (AW'(1) << l) - 1;
    return ((u ^ (u >> 1)) << l) | (a & m);
  endfunction

  function automatic int ref_pop(logic [AW-1:0] v);
    int n = 0;
    for (int i = 0; i < AW; i++) n += int'(v[i]);
    return n;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // drive at negedge, clock once, check at next negedge
  task automatic send(logic [AW-1:0] a, logic w, logic v, bit seq);
    logic [AW-1:0] nb;
    addr_i = a; wide_i = w; valid_i = v;
    @(posedge clk_i);
    @(negedge clk_i);
    if (v) begin
      nb = ref_enc(a, w);
      check(w ? "R3 bus" : "R2 bus", 64'(bus_o), 64'(nb));
      check("R6 toggles", 64'(toggles_o), 64'(ref_pop(nb ^ exp_bus)));
      if (seq) check("R4 one flip", 64'(toggles_o), 64'd1);
      check("R7 decode", 64'(dec_addr_o), 64'(a));
      exp_bus = nb; exp_dec = a; cur_addr = a; cur_wide = w;
    end else begin
      check("R5 hold bus", 64'(bus_o), 64'(exp_bus));
      check("R5 zero toggles", 64'(toggles_o), 64'd0);
      check("R5 decode held", 64'(dec_addr_o), 64'(exp_dec));
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    compared++; mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5eed_0042);
    addr_i = 32'hDEAD_BEEF; valid_i = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R1 bus reset", 64'(bus_o), 64'd0);
    check("R1 toggles reset", 64'(toggles_o), 64'd0);
    check("R1 decode reset", 64'(dec_addr_o), 64'd0);
    valid_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after release", 64'(bus_o), 64'd0);

    // directed: narrow run, idle with junk inputs, wide run
    send(32'h0000_1000, 1'b0, 1'b1, 0);
    for (int i = 1; i < 6; i++) send(32'h0000_1000 + 32'(4 * i), 1'b0, 1'b1, 1);
    send(32'hFFFF_0003, 1'b1, 1'b0, 0);
    send(32'h0000_2005, 1'b1, 1'b1, 0);
    for (int i = 1; i < 6; i++) send(32'h0000_2005 + 32'(8 * i), 1'b1, 1'b1, 1);

    // R8: wrap to zero in both modes
    send(32'hFFFF_FFFC, 1'b0, 1'b1, 0);
    send(32'h0000_0000, 1'b0, 1'b1, 1);
    check("R8 narrow wrap", 64'(bus_o), 64'd0);
    send(32'hFFFF_FFF8, 1'b1, 1'b1, 0);
    send(32'h0000_0000, 1'b1, 1'b1, 1);
    check("R8 wide wrap", 64'(bus_o), 64'd0);

    // constrained random mix
    for (int n = 0; n < 2000; n++) begin
      int unsigned r = $urandom % 10;
      if (r < 6)
        send(cur_addr + (cur_wide ? 32'd8 : 32'd4), cur_wide, 1'b1, 1);
      else if (r < 8)
        send($urandom, cur_wide, 1'b1, 0);
      else if (r < 9)
        send($urandom, 1'($urandom), 1'b0, 0);
      else
        send($urandom, ~cur_wide, 1'b1, 0);
    end

    finish_run();
  end
endmodule